// File: doc/BRIEF.md
# Peak-Hold Spectrum Bar Encoder

This block turns a stream of signed converter samples into bar-graph column patterns for a multi-band spectrum display. While the window enable is high, it follows the largest sample magnitude. The enable is raised once for each band's sample period.

When the end strobe arrives, the captured peak goes into a short circular history shared by all bands. The mean of that history is then reduced to a three-bit level. The level is expanded into a thermometer-style column pattern, and the pattern is stored in the slot of the band index presented with the strobe.

A display driver reads the stored patterns through a combinational read port, one band slot at a time. With the default parameters, samples are 8-bit two's complement, the history holds eight peaks, and there are eight band slots of 8 rows each.

Top module: `peak_bar_meter`

## Requirements
- R1: The peak stored at an end strobe is the largest magnitude among the valid in-window samples of that window. A valid sample presented in the same cycle as the end strobe is included.
- R2: Sample magnitude is the absolute value of the two's complement input. The most negative code 0x80 saturates to 127.
- R3: The held peak clears to zero in the first cycle that win_i is high after being low. Samples with win_i low or smp_vld_i low have no effect on the peak.
- R4: Each end strobe writes the peak into an eight-entry circular history, overwriting the oldest entry.
- R5: After each write, the mean is the sum of all eight history entries shifted right by three. History entries reset to zero, so early means include zeros.
- R6: The level is bits [6:4] of the 7-bit mean. The pattern for level n has bits 0 through n set, so level 0 gives 0x01 and level 7 gives 0xFF.
- R7: The pattern is written into the slot named by band_i as sampled with end_i, and all other slots keep their value. The new pattern is readable on rd_pattern_o after the third rising clock edge counted from the edge that samples end_i.
- R8: After reset every slot reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_i | input | 8 | Signed converter sample |
| smp_vld_i | input | 1 | Sample valid qualifier |
| win_i | input | 1 | Band sample window enable |
| end_i | input | 1 | End-of-window strobe, one cycle |
| band_i | input | 3 | Band slot for the pattern of this window |
| rd_band_i | input | 3 | Read port slot select |
| rd_pattern_o | output | 8 | Stored pattern of the selected slot |

## Verification
The assertions assume that end_i is a single-cycle pulse and that win_i stays high for at least one cycle before each strobe. They also assume that band_i is stable whenever end_i is high. The stimulus opens each window with a dedicated cycle, feeds samples, and pulses end_i exactly once while win_i is still high. It lowers win_i only after the strobe, and it waits for the full three-edge latency before opening the next window. It also drives samples while the window is closed, and invalid samples inside the window, to show they are ignored.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  localparam int unsigned SMP_W_DEF  = 8;
  localparam int unsigned DEPTH_DEF  = 8;
  localparam int unsigned BANDS_DEF  = 8;
  localparam int unsigned BAR_W_DEF  = 8;
endpackage

// File: rtl/pbm_peak.sv
module pbm_peak #(
  parameter int unsigned SMP_W = pbm_pkg::SMP_W_DEF,
  parameter int unsigned BAND_W = 3,
  localparam int unsigned MAG_W = SMP_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              smp_vld_i,
  input  logic              win_i,
  input  logic              end_i,
  input  logic [BAND_W-1:0] band_i,
  output logic              pk_vld_o,
  output logic [MAG_W-1:0]  pk_o,
  output logic [BAND_W-1:0] pk_band_o
);
  localparam logic [SMP_W-1:0] SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [MAG_W-1:0] MAG_MAX = {MAG_W{1'b1}};

  logic [SMP_W-1:0] neg_v;
  logic [MAG_W-1:0] mag, base, peak_nxt, peak_q;
  logic             win_q, start, take;

  always_comb begin
    neg_v = -smp_i;
    if (smp_i == SMP_MIN)        mag = MAG_MAX;
    else if (smp_i[SMP_W-1])     mag = neg_v[MAG_W-1:0];
    else                         mag = smp_i[MAG_W-1:0];
  end

  assign start    = win_i & ~win_q;
  assign base     = start ? '0 : peak_q;
  assign take     = win_i & smp_vld_i & (mag > base);
  assign peak_nxt = take ? mag : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= 1'b0;
      peak_q    <= '0;
      pk_vld_o  <= 1'b0;
      pk_o      <= '0;
      pk_band_o <= '0;
    end else begin
      win_q    <= win_i;
      peak_q   <= peak_nxt;
      pk_vld_o <= end_i;
      if (end_i) begin
        pk_o      <= peak_nxt;
        pk_band_o <= band_i;
      end
    end
  end

  AST_PEAK_COVERS_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i && smp_vld_i) |=> (peak_q >= $past(mag))); // R1
  AST_MIN_CODE_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_i == SMP_MIN) |-> (mag == MAG_MAX)); // R2
  AST_HOLD_OUTSIDE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i) |=> (peak_q == $past(peak_q))); // R3
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !smp_vld_i) |=> (peak_q == '0)); // R3
endmodule

// File: rtl/pbm_history.sv
module pbm_history #(
  parameter int unsigned MAG_W  = 7,
  parameter int unsigned DEPTH  = pbm_pkg::DEPTH_DEF,
  parameter int unsigned BAND_W = 3,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned SUM_W = MAG_W + PTR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [MAG_W-1:0]  din_i,
  input  logic [BAND_W-1:0] band_i,
  output logic              mean_vld_o,
  output logic [MAG_W-1:0]  mean_o,
  output logic [BAND_W-1:0] band_o
);
  localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(DEPTH * ((2 ** MAG_W) - 1));

  logic [MAG_W-1:0] hist_q [DEPTH];
  logic [PTR_W-1:0] wp_q;
  logic [SUM_W-1:0] sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
      wp_q       <= '0;
      sum_q      <= '0;
      mean_vld_o <= 1'b0;
      band_o     <= '0;
    end else begin
      mean_vld_o <= wr_i;
      if (wr_i) begin
        hist_q[wp_q] <= din_i;
        wp_q         <= wp_q + 1'b1;
        sum_q        <= sum_q - {{PTR_W{1'b0}}, hist_q[wp_q]} + {{PTR_W{1'b0}}, din_i};
        band_o       <= band_i;
      end
    end
  end

  assign mean_o = sum_q[SUM_W-1:PTR_W];

  AST_PTR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (wp_q == $past(wp_q) + 1'b1)); // R4
  AST_SLOT_LOADED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (hist_q[$past(wp_q)] == $past(din_i))); // R4
  AST_SUM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_q <= SUM_MAX); // R5
endmodule

// File: rtl/pbm_bar_enc.sv
module pbm_bar_enc #(
  parameter int unsigned MAG_W = 7,
  parameter int unsigned BAR_W = pbm_pkg::BAR_W_DEF,
  localparam int unsigned LVL_W = $clog2(BAR_W)
) (
  input  logic [MAG_W-1:0] mean_i,
  output logic [BAR_W-1:0] pat_o
);
  logic [LVL_W-1:0] lvl;
  assign lvl = mean_i[MAG_W-1 -: LVL_W];

  for (genvar r = 0; r < BAR_W; r++) begin : g_row
    assign pat_o[r] = (lvl >= LVL_W'(r));
  end
endmodule

// File: rtl/pbm_pattern_store.sv
module pbm_pattern_store #(
  parameter int unsigned BANDS = pbm_pkg::BANDS_DEF,
  parameter int unsigned BAR_W = pbm_pkg::BAR_W_DEF,
  localparam int unsigned BAND_W = $clog2(BANDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BAND_W-1:0] wr_band_i,
  input  logic [BAR_W-1:0]  wr_pat_i,
  input  logic [BAND_W-1:0] rd_band_i,
  output logic [BAR_W-1:0]  rd_pat_o
);
  logic [BAR_W-1:0] slot_q [BANDS];

  for (genvar b = 0; b < BANDS; b++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[b] <= '0;
      else if (wr_i && (wr_band_i == BAND_W'(b)))     slot_q[b] <= wr_pat_i;
    end
  end

  assign rd_pat_o = slot_q[rd_band_i];

  AST_SLOT_WRITTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (slot_q[$past(wr_band_i)] == $past(wr_pat_i))); // R7
endmodule

// File: rtl/peak_bar_meter.sv
module peak_bar_meter #(
  parameter int unsigned SMP_W = pbm_pkg::SMP_W_DEF,
  parameter int unsigned DEPTH = pbm_pkg::DEPTH_DEF,
  parameter int unsigned BANDS = pbm_pkg::BANDS_DEF,
  parameter int unsigned BAR_W = pbm_pkg::BAR_W_DEF,
  localparam int unsigned MAG_W  = SMP_W - 1,
  localparam int unsigned BAND_W = $clog2(BANDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              smp_vld_i,
  input  logic              win_i,
  input  logic              end_i,
  input  logic [BAND_W-1:0] band_i,
  input  logic [BAND_W-1:0] rd_band_i,
  output logic [BAR_W-1:0]  rd_pattern_o
);
  logic              pk_vld, mean_vld;
  logic [MAG_W-1:0]  pk, mean;
  logic [BAND_W-1:0] pk_band, mean_band;
  logic [BAR_W-1:0]  pat;

  pbm_peak #(.SMP_W(SMP_W), .BAND_W(BAND_W)) u_peak (
    .clk_i, .rst_ni, .smp_i, .smp_vld_i, .win_i, .end_i, .band_i,
    .pk_vld_o(pk_vld), .pk_o(pk), .pk_band_o(pk_band)
  );

  pbm_history #(.MAG_W(MAG_W), .DEPTH(DEPTH), .BAND_W(BAND_W)) u_hist (
    .clk_i, .rst_ni, .wr_i(pk_vld), .din_i(pk), .band_i(pk_band),
    .mean_vld_o(mean_vld), .mean_o(mean), .band_o(mean_band)
  );

  pbm_bar_enc #(.MAG_W(MAG_W), .BAR_W(BAR_W)) u_enc (
    .mean_i(mean), .pat_o(pat)
  );

  pbm_pattern_store #(.BANDS(BANDS), .BAR_W(BAR_W)) u_store (
    .clk_i, .rst_ni, .wr_i(mean_vld), .wr_band_i(mean_band), .wr_pat_i(pat),
    .rd_band_i, .rd_pat_o(rd_pattern_o)
  );

  AST_PATTERN_THERMO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_pattern_o & (rd_pattern_o + 1'b1)) == '0)); // R6
  AST_PATTERN_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mean_vld |-> (pat != '0)); // R6
  AST_END_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_i |=> !end_i); // R7
endmodule

// File: tb/sim_peak_bar_meter.sv
module sim_peak_bar_meter;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] smp_i = '0;
  logic       smp_vld_i = 1'b0;
  logic       win_i = 1'b0;
  logic       end_i = 1'b0;
  logic [2:0] band_i = '0;
  logic [2:0] rd_band_i = '0;
  logic [7:0] rd_pattern_o;

  int n_checks = 0;
  int n_fail = 0;

  int m_hist [8];
  int m_wp = 0;
  int m_peak = 0;
  int m_pat [8];

  always #4 clk_i = ~clk_i;

  peak_bar_meter u0 (
    .clk_i, .rst_ni, .smp_i, .smp_vld_i, .win_i, .end_i, .band_i,
    .rd_band_i, .rd_pattern_o
  );

  function automatic int mag_of(int s);
    if (s == -128) return 127;
    return (s < 0) ? -s : s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic check_slots(string req);
    for (int b = 0; b < 8; b++) begin
      rd_band_i = 3'(b);
      #1;
      check(req, int'(rd_pattern_o), m_pat[b]);
    end
  endtask

  task automatic open_win();
    win_i = 1'b1;
    m_peak = 0;
    tick();
  endtask

  task automatic feed(int s, bit vld);
    smp_i = 8'(s);
    smp_vld_i = vld;
    if (vld && win_i && mag_of(s) > m_peak) m_peak = mag_of(s);
    tick();
    smp_vld_i = 1'b0;
  endtask

  task automatic close_win(string req, int band, int s, bit vld);
    int sum;
    int lvl;
    end_i = 1'b1;
    band_i = 3'(band);
    smp_i = 8'(s);
    smp_vld_i = vld;
    if (vld && mag_of(s) > m_peak) m_peak = mag_of(s);
    tick();
    end_i = 1'b0;
    smp_vld_i = 1'b0;
    win_i = 1'b0;
    tick();
    tick();
    m_hist[m_wp] = m_peak;
    m_wp = (m_wp + 1) % 8;
    sum = 0;
    for (int i = 0; i < 8; i++) sum += m_hist[i];
    lvl = (sum / 8) / 16;
    m_pat[band] = (1 << (lvl + 1)) - 1;
    check_slots(req);
  endtask

  task automatic t_reset();
    check_slots("R8 reset slots");
  endtask

  task automatic t_basic();
    open_win();
    feed(10, 1); feed(100, 1); feed(50, 1);
    close_win("R1 R5 R6 R7 basic", 3, 0, 0);
    rd_band_i = 3'd3; #1;
    check("R6 level0 literal", int'(rd_pattern_o), 8'h01);
  endtask

  task automatic t_negative();
    open_win();
    feed(-20, 1); feed(-128, 1); feed(-5, 1);
    close_win("R2 min code", 5, 0, 0);
    rd_band_i = 3'd5; #1;
    check("R2 saturated level1", int'(rd_pattern_o), 8'h03);
  endtask

  task automatic t_ignore();
    feed(127, 1);
    feed(-127, 1);
    open_win();
    feed(127, 0);
    feed(5, 1);
    feed(-126, 0);
    close_win("R3 ignored and cleared", 1, 0, 0);
    rd_band_i = 3'd1; #1;
    check("R3 no leak literal", int'(rd_pattern_o), 8'h03);
  endtask

  task automatic t_end_sample();
    open_win();
    feed(3, 1);
    close_win("R1 end-cycle sample", 6, -100, 1);
    rd_band_i = 3'd6; #1;
    check("R1 end-cycle literal", int'(rd_pattern_o), 8'h07);
  endtask

  task automatic t_fill_wrap();
    for (int b = 0; b < 8; b++) begin
      open_win();
      feed(127, 1);
      close_win("R4 R5 fill", b, 0, 0);
    end
    rd_band_i = 3'd7; #1;
    check("R6 full scale literal", int'(rd_pattern_o), 8'hFF);
    open_win();
    feed(90, 0);
    close_win("R4 wrap oldest", 2, 0, 0);
    rd_band_i = 3'd2; #1;
    check("R4 wrap literal", int'(rd_pattern_o), 8'h7F);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_hist[i] = 0;
      m_pat[i] = 0;
    end
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_basic();
    t_negative();
    t_ignore();
    t_end_sample();
    t_fill_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule